// File: doc/BRIEF.md
# PHY Test-Port Write Sequencer

This block carries out one write into a PHY's internal configuration space through a narrow test port. A host presents an 8-bit register code and an 8-bit data byte, pulses a start request, and the block steps the test clock, test enable and shared 8-bit data-in bus through a fixed five-step pattern. The code is taken by the PHY on the falling test-clock edge while enable is high; the data byte is taken on the following rising edge while enable is low.

Every step is held for a host-chosen number of system clocks so that the pattern can be slowed to whatever the PHY's configuration clock domain tolerates. Busy covers the whole write and a single-cycle done pulse marks its end. The port levels are also presented as two 32-bit control words in the layout a neighbouring register block decodes.

Top module: `phy_tport_wr`

## Requirements
- R1: After reset: test clock 1, test clear 0, test enable 0, data-in 0x00, busy 0, done 0.
- R2: A start sampled high while idle is accepted; busy is 1 from the next cycle, and code, data and hold are captured at that edge.
- R3: Step 1 drives test clock 1 and test enable 0; data-in keeps its previous value.
- R4: Step 2 drives test enable 1 and data-in = code, test clock still 1.
- R5: Step 3 drives test clock 0 with test enable 1 and data-in = code, so test clock only falls while enable is 1.
- R6: Step 4 drives test enable 0 and data-in = data byte, test clock still 0.
- R7: Step 5 drives test clock 1 with enable 0; afterwards the port rests with test clock 1, enable 0 and data-in holding the data byte.
- R8: Each step lasts max(hold,1) system clocks; a hold of 0 behaves as 1, so a write with hold H ends with done 5*max(H,1)+1 cycles after the accepting edge.
- R9: Done is 1 for exactly one cycle, in the cycle after step 5 ends, and busy is 0 in that cycle.
- R10: Start requests while busy are ignored; code, data and hold changes during a write have no effect on it.
- R11: Control word 0 carries test clock in bit 1 and test clear in bit 0; control word 1 carries enable in bit 16, a data-out field in bits 15:8 fixed at 0, and data-in in bits 7:0; all other bits are 0.
- R12: Test clear stays 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Write request |
| code_i | input | 8 | Register code to write |
| data_i | input | 8 | Data byte to write |
| hold_i | input | HOLD_W | Clocks per step (0 treated as 1) |
| busy_o | output | 1 | Write in progress |
| done_o | output | 1 | One-cycle end-of-write pulse |
| tclk_o | output | 1 | Test clock |
| tclr_o | output | 1 | Test clear |
| ten_o | output | 1 | Test enable |
| tdin_o | output | 8 | Test data-in bus |
| ctrl0_o | output | 32 | Control word 0 image |
| ctrl1_o | output | 32 | Control word 1 image |

## Verification
The hardest case is a start that lands exactly on the done cycle or during the last held cycle of step 5, where the idle check and the step-5 exit meet. The bench holds start high continuously across writes, with code, data and hold changing mid-write, so a request sits at every boundary cycle, including the one-cycle idle window right after done. Hold values of 0, 1 and 3 show whether the per-step counter reloads correctly at each step change.

// File: rtl/phy_tport_pkg.sv
package phy_tport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CKHI  = 3'd1,
    ST_CODE  = 3'd2,
    ST_CKLO  = 3'd3,
    ST_DATA  = 3'd4,
    ST_CKUP  = 3'd5
  } step_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/tport_hold_timer.sv
module tport_hold_timer #(
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              reload_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              expired_o
);
  logic [HOLD_W-1:0] hold_q, cnt_q, hold_eff;

  assign hold_eff  = (hold_i == '0) ? HOLD_W'(1) : hold_i;
  assign expired_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= HOLD_W'(1);
      cnt_q  <= '0;
    end else if (arm_i) begin
      hold_q <= hold_eff;
      cnt_q  <= hold_eff - HOLD_W'(1);
    end else if (reload_i) begin
      cnt_q  <= hold_q - HOLD_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - HOLD_W'(1);
    end
  end

  assert_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && !reload_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - HOLD_W'(1)));
endmodule

// File: rtl/tport_step_seq.sv
module tport_step_seq
  import phy_tport_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  expired_i,
  output step_e step_o,
  output logic  accept_o,
  output logic  reload_o,
  output logic  done_o
);
  step_e step_q, step_d;
  logic  done_q, adv;

  assign accept_o = (step_q == ST_IDLE) && start_i;
  assign adv      = (step_q != ST_IDLE) && expired_i;
  assign reload_o = adv && (step_q != ST_CKUP);
  assign step_o   = step_q;
  assign done_o   = done_q;

  always_comb begin
    step_d = step_q;
    if (accept_o) step_d = ST_CKHI;
    else if (adv) begin
      case (step_q)
        ST_CKHI: step_d = ST_CODE;
        ST_CODE: step_d = ST_CKLO;
        ST_CKLO: step_d = ST_DATA;
        ST_DATA: step_d = ST_CKUP;
        default: step_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= adv && (step_q == ST_CKUP);
    end
  end

  assert_step_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q != ST_IDLE && !expired_i) |=> (step_q == $past(step_q)));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (step_q == ST_IDLE));
  assert_busy_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q != ST_IDLE && !expired_i && start_i) |=> (step_q != ST_IDLE));
endmodule

// File: rtl/tport_pin_drive.sv
module tport_pin_drive
  import phy_tport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  step_e             step_i,
  input  logic              accept_i,
  input  logic              reload_i,
  input  logic [BYTE_W-1:0] code_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              tclk_o,
  output logic              tclr_o,
  output logic              ten_o,
  output logic [BYTE_W-1:0] tdin_o
);
  logic [BYTE_W-1:0] code_q, data_q, din_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      data_q <= '0;
      din_q  <= '0;
    end else begin
      if (accept_i) begin
        code_q <= code_i;
        data_q <= data_i;
      end
      if (reload_i && step_i == ST_CKHI) din_q <= code_q;
      if (reload_i && step_i == ST_CKLO) din_q <= data_q;
    end
  end

  // clock low only while the code/data pair is being presented around the falling edge
  assign tclk_o = !(step_i == ST_CKLO || step_i == ST_DATA);
  assign ten_o  = (step_i == ST_CODE) || (step_i == ST_CKLO);
  assign tclr_o = 1'b0;
  assign tdin_o = din_q;

  assert_code_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tclk_o) |-> (ten_o && tdin_o == code_q));
  assert_data_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tclk_o) |-> (!ten_o && tdin_o == data_q));
  assert_latch_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i != ST_IDLE) |=> ($stable(code_q) && $stable(data_q)));
endmodule

// File: rtl/phy_tport_wr.sv
module phy_tport_wr
  import phy_tport_pkg::*;
#(
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        code_i,
  input  logic [7:0]        data_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              tclk_o,
  output logic              tclr_o,
  output logic              ten_o,
  output logic [7:0]        tdin_o,
  output logic [31:0]       ctrl0_o,
  output logic [31:0]       ctrl1_o
);
  localparam int unsigned EN_BIT = 16;

  step_e step;
  logic  accept, reload, expired;

  tport_hold_timer #(.HOLD_W(HOLD_W)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(accept), .reload_i(reload),
    .hold_i(hold_i), .expired_o(expired)
  );

  tport_step_seq i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .expired_i(expired),
    .step_o(step), .accept_o(accept), .reload_o(reload), .done_o(done_o)
  );

  tport_pin_drive i_drive (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .accept_i(accept),
    .reload_i(reload), .code_i(code_i), .data_i(data_i),
    .tclk_o(tclk_o), .tclr_o(tclr_o), .ten_o(ten_o), .tdin_o(tdin_o)
  );

  assign busy_o = (step != ST_IDLE);

  always_comb begin
    ctrl0_o          = '0;
    ctrl0_o[1]       = tclk_o;
    ctrl0_o[0]       = tclr_o;
    ctrl1_o          = '0;
    ctrl1_o[EN_BIT]  = ten_o;
    ctrl1_o[15:8]    = 8'h00;
    ctrl1_o[7:0]     = tdin_o;
  end

  assert_done_not_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_accept_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
endmodule

// File: tb/test_phy_tport_wr.sv
`timescale 1ns/1ps
module test_phy_tport_wr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] code = 8'h00, data = 8'h00, hold = 8'd1;
  logic       busy, done, tclk, tclr, ten;
  logic [7:0] tdin;
  logic [31:0] c0, c1;

  int n_run = 0, n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  phy_tport_wr i_phy_tport_wr (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .code_i(code), .data_i(data),
    .hold_i(hold), .busy_o(busy), .done_o(done), .tclk_o(tclk), .tclr_o(tclr),
    .ten_o(ten), .tdin_o(tdin), .ctrl0_o(c0), .ctrl1_o(c1)
  );

  // behavioural reference
  int m_step, m_cnt, m_h;
  logic [7:0] m_code, m_data, m_din;
  logic m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_cnt = 0; m_h = 1; m_code = 0; m_data = 0; m_din = 0; m_done = 0;
    end else begin
      cyc++;
      m_done = 0;
      if (m_step == 0) begin
        if (start) begin
          m_step = 1; m_h = (hold == 0) ? 1 : int'(hold); m_cnt = m_h - 1;
          m_code = code; m_data = data;
        end
      end else if (m_cnt > 0) m_cnt--;
      else if (m_step == 5) begin m_step = 0; m_done = 1; end
      else begin
        m_step++; m_cnt = m_h - 1;
        if (m_step == 2) m_din = m_code;
        if (m_step == 4) m_din = m_data;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) if (rst_n) begin
    logic e_tclk, e_en;
    e_tclk = !(m_step == 3 || m_step == 4);
    e_en   = (m_step == 2 || m_step == 3);
    chk("R3/R5/R7 tclk", tclk, e_tclk);
    chk("R4/R5/R6 ten", ten, e_en);
    chk("R4/R6/R7 tdin", tdin, m_din);
    chk("R12 tclr", tclr, 0);
    chk("R2/R10 busy", busy, m_step != 0);
    chk("R9 done", done, m_done);
    chk("R11 ctrl0", c0, {30'd0, e_tclk, 1'b0});
    chk("R11 ctrl1", c1, {15'd0, e_en, 8'h00, m_din});
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_one(logic [7:0] c, logic [7:0] d, logic [7:0] h, int expect_len);
    int t;
    code = c; data = d; hold = h; start = 1'b1;
    @(negedge clk);          // accepting edge just passed
    start = 1'b0;
    code = ~c; data = ~d; hold = h + 8'd2;   // R10: changes mid-write ignored
    t = 1;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk("R8 latency", t, expect_len);
    chk("R7 rest data", tdin, d);
  endtask

  initial begin
    cycles(3);
    chk("R1 tclk", tclk, 1); chk("R1 ten", ten, 0); chk("R1 tdin", tdin, 0);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R12 clr", tclr, 0);
    rst_n = 1'b1;
    cycles(2);
    write_one(8'hA5, 8'h3C, 8'd1, 6);
    cycles(2);
    write_one(8'h12, 8'hC8, 8'd3, 16);
    cycles(1);
    write_one(8'h7E, 8'h81, 8'd0, 6);   // R8: hold 0 acts as 1
    // R10: start held high across back-to-back writes
    code = 8'h44; data = 8'h99; hold = 8'd2; start = 1'b1;
    cycles(40);
    start = 1'b0;
    cycles(15);
    chk("R7 rest tclk", tclk, 1);
    chk("R9 idle busy", busy, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule